// File: doc/BRIEF.md
# Snooping Directory Controller for a Two-Way Write-Back Cache (MEI)

This block holds the tag and coherency-state directory of a two-way set-associative write-back data cache with 32-byte blocks. Each block is either Modified, Exclusive or Invalid; there is no shared state. The processor side looks up an address, learns hit or miss, the matching way and the current state, and marks a hit block Modified on a local write. On a miss to a coherent page it requests a block fill from the bus. Because no copy is ever shared, the fill is always issued as a read-with-intent-to-modify, and the block is installed as Exclusive.

The bus side watches global transactions. Since this cache never shares a block, a snooped read is handled like a snooped write: a Modified copy is written back and invalidated, and an Exclusive copy is simply invalidated. The one exception is a caching-inhibited read. That read leaves an Exclusive copy alone, and it turns a Modified copy into Exclusive after the write-back, so that uncached masters can read without thrashing the cache. A snoop that needs a write-back is answered with address retry. The write-back itself is a request/acknowledge handshake.

Data storage, victim choice, address translation and bus arbitration sit outside this block. The way to fill is supplied with the fill acknowledge.

Top module: `mei_dir_ctrl`

## Requirements
- R1: After reset is released, `cpu_ready` stays low for exactly 128 clock cycles while every directory entry is swept to Invalid. After the sweep, every lookup misses until a fill completes.
- R2: Address bits [4:0] are the byte offset, bits [11:5] select one of 128 sets, and bits [31:12] are the tag. A lookup hits only when the tag matches a non-Invalid entry of the indexed set. On a hit it reports the way and the state as it stands before any update. State codes are Invalid = 2'b00, Exclusive = 2'b10 and Modified = 2'b11.
- R3: A coherent lookup (`cpu_wim` = 3'b001) that misses raises `fill_req` in the next cycle. At the same time `fill_addr` gives the block-aligned address and `fill_tt` gives 5'b01110 (read-with-intent-to-modify). All three are held until `fill_ack`, and `cpu_ready` stays low meanwhile.
- R4: On `fill_ack`, the tag is written into way `fill_way` of that set with state Exclusive. `fill_req` drops in the next cycle.
- R5: A local write that hits an Exclusive or Modified block makes it Modified. It raises neither `fill_req` nor `wb_req`.
- R6: A lookup whose `cpu_wim` is not 3'b001 reports no hit, starts no fill and changes no state.
- R7: A global snoop other than a caching-inhibited read that hits an Exclusive block invalidates it. It raises neither `snp_retry` nor `wb_req`.
- R8: A global snoop that hits a Modified block raises `snp_retry` in the same cycle and `wb_req` in the next, with `wb_addr` set to the block address. `wb_req` is held until `wb_ack`. The block then becomes Invalid, or Exclusive when the snoop type was the caching-inhibited read 5'b01010.
- R9: A caching-inhibited read snoop (`snp_tt` = 5'b01010) that hits an Exclusive block changes nothing and raises neither retry nor write-back.
- R10: A snoop that misses, or that is not global (`snp_gbl` low), raises no retry and changes no state.
- R11: When a global snoop and a processor lookup address the same set in the same cycle, the snoop wins. `cpu_ready` is low and `cpu_hit` is low in that cycle, and the snoop takes full effect. A snoop to another set does not stall the lookup.
- R12: While a write-back is outstanding, every global snoop is retried and changes no state. While a fill is outstanding, a global snoop to the set of that fill is retried and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor lookup valid |
| cpu_we | input | 1 | Lookup is a store |
| cpu_wim | input | 3 | Page attributes of the access; 3'b001 is coherent write-back |
| cpu_addr | input | 32 | Physical address of the access |
| cpu_ready | output | 1 | Lookup accepted this cycle |
| cpu_hit | output | 1 | Accepted lookup hit |
| cpu_way | output | 1 | Way that hit |
| cpu_state | output | 2 | State of the hit block before update |
| fill_req | output | 1 | Block fill request to the bus |
| fill_addr | output | 32 | Block-aligned fill address |
| fill_tt | output | 5 | Transfer type of the fill |
| fill_way | input | 1 | Way to install the fill in, valid with fill_ack |
| fill_ack | input | 1 | Fill completed |
| snp_valid | input | 1 | Snooped bus address valid |
| snp_gbl | input | 1 | Snooped transaction is global |
| snp_tt | input | 5 | Snooped transfer type |
| snp_addr | input | 32 | Snooped address |
| snp_retry | output | 1 | Address retry for the snooped transaction |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | 32 | Block address of the write-back |
| wb_ack | input | 1 | Write-back completed |

## Verification
A processor lookup and a bus snoop can land in the same cycle. When they address the same set, the directory must serve the snoop and hold off the processor. The bench provokes this by making a block Modified and then driving a store-class snoop and a read lookup to that block on the same clock. It expects `cpu_ready` and `cpu_hit` low together with `snp_retry` high, then a write-back. A later lookup must miss and start a fill. The same pairing aimed at different sets must leave the lookup served, with its hit intact.

// File: rtl/mei_dir_pkg.sv
`timescale 1ns/1ps
// Shared types and codes for the snooping MEI directory.
// Assumes a bus whose transfer types are 5-bit codes.
package mei_dir_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_EXC = 2'b10,
        ST_MOD = 2'b11
    } mei_st_e;

    localparam logic [4:0] TT_RWITM   = 5'b01110;
    localparam logic [4:0] TT_CI_READ = 5'b01010;
    localparam logic [2:0] WIM_COHERENT = 3'b001;
endpackage

// File: rtl/mei_dir_store.sv
`timescale 1ns/1ps
// Tag and state storage for all sets and ways, with two read ports
// (processor and snoop) and two write ports. The state-only port (snoop side)
// is applied last, so it wins on the same entry. After reset, a sequential
// sweep clears every state to Invalid before `swept` rises.
// Assumes the caller keeps writes idle until `swept` is high.
module mei_dir_store
    import mei_dir_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int TAG_W = 20,
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             swept,
    input  logic [IDX_W-1:0] la_idx,
    input  logic [TAG_W-1:0] la_tag,
    output logic             la_hit,
    output logic [WAY_W-1:0] la_way,
    output mei_st_e          la_st,
    input  logic [IDX_W-1:0] lb_idx,
    input  logic [TAG_W-1:0] lb_tag,
    output logic             lb_hit,
    output logic [WAY_W-1:0] lb_way,
    output mei_st_e          lb_st,
    input  logic             ws_en,
    input  logic [IDX_W-1:0] ws_idx,
    input  logic [WAY_W-1:0] ws_way,
    input  mei_st_e          ws_st,
    input  logic             wc_en,
    input  logic             wc_tag_en,
    input  logic [IDX_W-1:0] wc_idx,
    input  logic [WAY_W-1:0] wc_way,
    input  logic [TAG_W-1:0] wc_tag,
    input  mei_st_e          wc_st
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    mei_st_e          st_q  [SETS][WAYS];
    logic [IDX_W-1:0] sweep_ptr;
    logic             swept_q;
    logic [WAYS-1:0]  ma, mb;

    assign swept = swept_q;

    // Walk the sweep pointer once over all sets after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_ptr <= '0;
            swept_q   <= 1'b0;
        end else if (!swept_q) begin
            sweep_ptr <= sweep_ptr + 1'b1;
            if (sweep_ptr == IDX_W'(SETS - 1))
                swept_q <= 1'b1;
        end
    end

    // Clear during the sweep, otherwise apply the fill/local port, then the snoop port.
    always_ff @(posedge clk) begin
        if (!swept_q) begin
            for (int w = 0; w < WAYS; w++)
                st_q[sweep_ptr][w] <= ST_INV;
        end else begin
            if (wc_en) begin
                st_q[wc_idx][wc_way] <= wc_st;
                if (wc_tag_en)
                    tag_q[wc_idx][wc_way] <= wc_tag;
            end
            if (ws_en)
                st_q[ws_idx][ws_way] <= ws_st;
        end
    end

    // One tag comparator per way, for each read port.
    for (genvar gw = 0; gw < WAYS; gw++) begin : g_cmp
        assign ma[gw] = (st_q[la_idx][gw] != ST_INV) && (tag_q[la_idx][gw] == la_tag);
        assign mb[gw] = (st_q[lb_idx][gw] != ST_INV) && (tag_q[lb_idx][gw] == lb_tag);
    end

    // Encode the processor-port match; the lowest matching way wins.
    always_comb begin
        la_hit = 1'b0;
        la_way = '0;
        la_st  = ST_INV;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (ma[w]) begin
                la_hit = 1'b1;
                la_way = WAY_W'(w);
                la_st  = st_q[la_idx][w];
            end
        end
    end

    // Encode the snoop-port match.
    always_comb begin
        lb_hit = 1'b0;
        lb_way = '0;
        lb_st  = ST_INV;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (mb[w]) begin
                lb_hit = 1'b1;
                lb_way = WAY_W'(w);
                lb_st  = st_q[lb_idx][w];
            end
        end
    end

    // R1
    // sweep_done_stays_chk
    sweep_done_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swept_q |=> swept_q);

    // R2
    // single_way_hit_chk
    single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swept_q |-> ($onehot0(ma) && $onehot0(mb)));
endmodule

// File: rtl/mei_snoop_policy.sv
`timescale 1ns/1ps
// Decides the response to one global snoop: retry, in-place state update,
// or start of a write-back with the state the block takes on completion.
// Assumes `snp_st` is the state of the matching way, valid when `snp_hit` is high.
module mei_snoop_policy
    import mei_dir_pkg::*;
(
    input  logic       snp_act,
    input  logic       snp_hit,
    input  mei_st_e    snp_st,
    input  logic [4:0] snp_tt,
    input  logic       blocked,
    output logic       retry,
    output logic       upd_en,
    output mei_st_e    upd_st,
    output logic       wb_start,
    output mei_st_e    wb_next
);
    logic ci_read;
    assign ci_read = (snp_tt == TT_CI_READ);

    // Map the snooped state and transfer type to an action.
    always_comb begin
        retry    = 1'b0;
        upd_en   = 1'b0;
        upd_st   = ST_INV;
        wb_start = 1'b0;
        wb_next  = ST_INV;
        if (snp_act) begin
            if (blocked) begin
                retry = 1'b1;
            end else if (snp_hit && snp_st == ST_MOD) begin
                retry    = 1'b1;
                wb_start = 1'b1;
                wb_next  = ci_read ? ST_EXC : ST_INV;
            end else if (snp_hit && snp_st == ST_EXC && !ci_read) begin
                upd_en = 1'b1;
                upd_st = ST_INV;
            end
        end
    end
endmodule

// File: rtl/mei_dir_ctrl.sv
`timescale 1ns/1ps
// Top of the MEI snooping directory controller. It serves processor lookups,
// issues fills as read-with-intent-to-modify, and answers global snoops with
// invalidate, write-back plus retry, or no action. A snoop to the set the
// processor addresses in the same cycle takes priority.
// Assumes victim choice and data movement are handled outside the block.
module mei_dir_ctrl
    import mei_dir_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 32,
    parameter int IDX_W     = 7,
    parameter int WAYS      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [2:0]        cpu_wim,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] cpu_way,
    output logic [1:0]        cpu_state,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [4:0]        fill_tt,
    input  logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] fill_way,
    input  logic              fill_ack,
    input  logic              snp_valid,
    input  logic              snp_gbl,
    input  logic [4:0]        snp_tt,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_retry,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack
);
    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [IDX_W-1:0] cpu_idx, snp_idx, fill_idx, wb_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag, fill_tag;
    logic             swept, la_hit, lb_hit, snp_act, wim_ok, cpu_go, blocked;
    logic [WAY_W-1:0] la_way, lb_way, wb_way_q;
    mei_st_e          la_st, lb_st, upd_st, wb_next, wb_next_q, ws_st, wc_st;
    logic             upd_en, wb_start, fill_busy, wb_busy;
    logic             ws_en, wc_en, wc_tag_en, wb_done, fill_done, local_wr;
    logic [IDX_W-1:0] ws_idx, wc_idx;
    logic [WAY_W-1:0] ws_way, wc_way;
    logic [ADDR_W-1:0] fill_addr_q, wb_addr_q;
    logic             unused_bits;

    assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
    assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign snp_idx  = snp_addr[OFF_W +: IDX_W];
    assign snp_tag  = snp_addr[ADDR_W-1 -: TAG_W];
    assign fill_idx = fill_addr_q[OFF_W +: IDX_W];
    assign fill_tag = fill_addr_q[ADDR_W-1 -: TAG_W];
    assign wb_idx   = wb_addr_q[OFF_W +: IDX_W];
    assign unused_bits = ^{cpu_addr[OFF_W-1:0], snp_addr[OFF_W-1:0], fill_addr_q[OFF_W-1:0], wb_addr_q[OFF_W-1:0]};

    // Request qualification and the snoop-over-processor priority.
    assign snp_act   = snp_valid && snp_gbl && swept;
    assign wim_ok    = (cpu_wim == WIM_COHERENT);
    assign cpu_ready = swept && !fill_busy && !wb_busy && !(snp_act && snp_idx == cpu_idx);
    assign cpu_go    = cpu_req && cpu_ready;
    assign cpu_hit   = cpu_go && wim_ok && la_hit;
    assign cpu_way   = la_way;
    assign cpu_state = cpu_hit ? la_st : ST_INV;
    assign blocked   = wb_busy || (fill_busy && fill_idx == snp_idx);

    mei_dir_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_store (
        .clk(clk), .rst_n(rst_n), .swept(swept),
        .la_idx(cpu_idx), .la_tag(cpu_tag), .la_hit(la_hit), .la_way(la_way), .la_st(la_st),
        .lb_idx(snp_idx), .lb_tag(snp_tag), .lb_hit(lb_hit), .lb_way(lb_way), .lb_st(lb_st),
        .ws_en(ws_en), .ws_idx(ws_idx), .ws_way(ws_way), .ws_st(ws_st),
        .wc_en(wc_en), .wc_tag_en(wc_tag_en), .wc_idx(wc_idx), .wc_way(wc_way),
        .wc_tag(fill_tag), .wc_st(wc_st)
    );

    mei_snoop_policy u_policy (
        .snp_act(snp_act), .snp_hit(lb_hit), .snp_st(lb_st), .snp_tt(snp_tt),
        .blocked(blocked), .retry(snp_retry), .upd_en(upd_en), .upd_st(upd_st),
        .wb_start(wb_start), .wb_next(wb_next)
    );

    // Track the single outstanding fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_busy   <= 1'b0;
            fill_addr_q <= '0;
        end else if (fill_busy) begin
            if (fill_ack)
                fill_busy <= 1'b0;
        end else if (cpu_go && wim_ok && !la_hit) begin
            fill_busy   <= 1'b1;
            fill_addr_q <= {cpu_tag, cpu_idx, {OFF_W{1'b0}}};
        end
    end

    // Track the single outstanding write-back and the state it leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_busy   <= 1'b0;
            wb_addr_q <= '0;
            wb_way_q  <= '0;
            wb_next_q <= ST_INV;
        end else if (wb_busy) begin
            if (wb_ack)
                wb_busy <= 1'b0;
        end else if (wb_start) begin
            wb_busy   <= 1'b1;
            wb_addr_q <= {snp_tag, snp_idx, {OFF_W{1'b0}}};
            wb_way_q  <= lb_way;
            wb_next_q <= wb_next;
        end
    end

    // State-only port: a completed write-back or an in-place snoop invalidate.
    assign wb_done = wb_busy && wb_ack;
    assign ws_en   = wb_done || upd_en;
    assign ws_idx  = wb_done ? wb_idx    : snp_idx;
    assign ws_way  = wb_done ? wb_way_q  : lb_way;
    assign ws_st   = wb_done ? wb_next_q : upd_st;

    // Tag-and-state port: an installed fill or a local store hit.
    assign fill_done = fill_busy && fill_ack;
    assign local_wr  = cpu_hit && cpu_we;
    assign wc_en     = fill_done || local_wr;
    assign wc_tag_en = fill_done;
    assign wc_idx    = fill_done ? fill_idx : cpu_idx;
    assign wc_way    = fill_done ? fill_way : la_way;
    assign wc_st     = fill_done ? ST_EXC   : ST_MOD;

    assign fill_req  = fill_busy;
    assign fill_addr = fill_addr_q;
    assign fill_tt   = fill_busy ? TT_RWITM : 5'b00000;
    assign wb_req    = wb_busy;
    assign wb_addr   = wb_addr_q;

    // R3
    // fill_hold_chk
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr)));

    // R3
    // stall_in_fill_chk
    stall_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !cpu_ready);

    // R2
    // hit_state_valid_chk
    hit_state_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> (cpu_state != ST_INV));

    // R8
    // wb_after_retry_chk
    wb_after_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_start |=> (wb_req && wb_addr[ADDR_W-1:OFF_W] == $past(snp_addr[ADDR_W-1:OFF_W])));

    // R8
    // wb_hold_chk
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

    // R12
    // retry_during_wb_chk
    retry_during_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && snp_valid && snp_gbl) |-> snp_retry);
endmodule

// File: tb/mei_dir_ctrl_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, then directed tests.
module mei_dir_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [2:0]  cpu_wim = 3'b001;
    logic [31:0] cpu_addr = '0;
    logic        cpu_ready, cpu_hit;
    logic [0:0]  cpu_way;
    logic [1:0]  cpu_state;
    logic        fill_req;
    logic [31:0] fill_addr;
    logic [4:0]  fill_tt;
    logic [0:0]  fill_way = 1'b0;
    logic        fill_ack = 1'b0;
    logic        snp_valid = 1'b0, snp_gbl = 1'b0;
    logic [4:0]  snp_tt = '0;
    logic [31:0] snp_addr = '0;
    logic        snp_retry, wb_req;
    logic [31:0] wb_addr;
    logic        wb_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mei_dir_ctrl u_mei_dir_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wim(cpu_wim), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_way(cpu_way), .cpu_state(cpu_state),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_tt(fill_tt),
        .fill_way(fill_way), .fill_ack(fill_ack),
        .snp_valid(snp_valid), .snp_gbl(snp_gbl), .snp_tt(snp_tt), .snp_addr(snp_addr),
        .snp_retry(snp_retry), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack)
    );

    localparam logic [31:0] A_ADR = 32'h1234_5060;  // set 3
    localparam logic [31:0] B_ADR = 32'hABCD_E060;  // set 3
    localparam logic [31:0] C_ADR = 32'h0077_7C80;  // set 100
    localparam logic [31:0] D_ADR = 32'h5555_5C80;  // set 100
    localparam logic [1:0] SI = 2'b00, SE = 2'b10, SM = 2'b11;

    typedef struct packed {
        logic        op;       // 0 processor access, 1 snoop
        logic        we;
        logic [2:0]  wim;
        logic [31:0] addr;
        logic [4:0]  tt;
        logic        gbl;
        logic        way;      // expected hit way, or fill way on a miss
        logic        exp_hit;
        logic [1:0]  exp_st;
        logic        exp_retry;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [21] = '{
        '{1'b0, 1'b0, 3'b001, A_ADR, 5'b00000, 1'b0, 1'b0, 1'b0, SI, 1'b0, 4'd3},  // R3 miss, fill way0
        '{1'b0, 1'b0, 3'b001, A_ADR, 5'b00000, 1'b0, 1'b0, 1'b1, SE, 1'b0, 4'd4},  // R4 now Exclusive
        '{1'b0, 1'b0, 3'b001, B_ADR, 5'b00000, 1'b0, 1'b1, 1'b0, SI, 1'b0, 4'd3},  // R3 fill way1
        '{1'b0, 1'b0, 3'b001, B_ADR, 5'b00000, 1'b0, 1'b1, 1'b1, SE, 1'b0, 4'd2},  // R2 hit way1
        '{1'b0, 1'b1, 3'b001, A_ADR, 5'b00000, 1'b0, 1'b0, 1'b1, SE, 1'b0, 4'd5},  // R5 store hit
        '{1'b0, 1'b0, 3'b001, A_ADR, 5'b00000, 1'b0, 1'b0, 1'b1, SM, 1'b0, 4'd5},  // R5 Modified
        '{1'b1, 1'b0, 3'b000, A_ADR, 5'b01010, 1'b1, 1'b0, 1'b0, SI, 1'b1, 4'd8},  // R8 CI read on M
        '{1'b0, 1'b0, 3'b001, A_ADR, 5'b00000, 1'b0, 1'b0, 1'b1, SE, 1'b0, 4'd8},  // R8 demoted to E
        '{1'b1, 1'b0, 3'b000, A_ADR, 5'b01010, 1'b1, 1'b0, 1'b0, SI, 1'b0, 4'd9},  // R9 CI read on E
        '{1'b0, 1'b0, 3'b001, A_ADR, 5'b00000, 1'b0, 1'b0, 1'b1, SE, 1'b0, 4'd9},  // R9 still E
        '{1'b1, 1'b0, 3'b000, B_ADR, 5'b00010, 1'b1, 1'b0, 1'b0, SI, 1'b0, 4'd7},  // R7 invalidate E
        '{1'b0, 1'b0, 3'b101, B_ADR, 5'b00000, 1'b0, 1'b1, 1'b0, SI, 1'b0, 4'd6},  // R6 non-coherent page
        '{1'b0, 1'b0, 3'b001, B_ADR, 5'b00000, 1'b0, 1'b1, 1'b0, SI, 1'b0, 4'd7},  // R7 B gone, refill
        '{1'b1, 1'b0, 3'b000, C_ADR, 5'b00010, 1'b1, 1'b0, 1'b0, SI, 1'b0, 4'd10}, // R10 snoop miss
        '{1'b1, 1'b0, 3'b000, A_ADR, 5'b00010, 1'b0, 1'b0, 1'b0, SI, 1'b0, 4'd10}, // R10 not global
        '{1'b0, 1'b0, 3'b001, A_ADR, 5'b00000, 1'b0, 1'b0, 1'b1, SE, 1'b0, 4'd10}, // R10 unchanged
        '{1'b0, 1'b1, 3'b001, A_ADR, 5'b00000, 1'b0, 1'b0, 1'b1, SE, 1'b0, 4'd5},  // R5 store hit
        '{1'b1, 1'b0, 3'b000, A_ADR, 5'b00010, 1'b1, 1'b0, 1'b0, SI, 1'b1, 4'd8},  // R8 snoop on M
        '{1'b0, 1'b0, 3'b101, A_ADR, 5'b00000, 1'b0, 1'b0, 1'b0, SI, 1'b0, 4'd6},  // R6 no fill
        '{1'b0, 1'b0, 3'b001, A_ADR, 5'b00000, 1'b0, 1'b0, 1'b0, SI, 1'b0, 4'd8},  // R8 now Invalid
        '{1'b0, 1'b0, 3'b001, A_ADR, 5'b00000, 1'b0, 1'b0, 1'b1, SE, 1'b0, 4'd4}   // R4 refilled E
    };

    task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Processor access; a coherent miss is completed with a fill into fway.
    task automatic cpu_op(input logic [31:0] a, input logic we, input logic [2:0] wim,
                          input logic eh, input logic [1:0] es, input logic fway, input int rq);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_wim = wim; cpu_addr = a;
        #1;
        check(rq, "cpu_ready", 32'(cpu_ready), 32'd1);
        check(rq, "cpu_hit", 32'(cpu_hit), 32'(eh));
        if (eh) begin
            check(rq, "cpu_state", 32'(cpu_state), 32'(es));
            check(rq, "cpu_way", 32'(cpu_way), 32'(fway));
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        #1;
        if (!eh && wim == 3'b001) begin
            check(rq, "fill_req", 32'(fill_req), 32'd1);
            check(rq, "fill_addr", fill_addr, {a[31:5], 5'b0});
            check(rq, "fill_tt", 32'(fill_tt), 32'b01110);
            check(rq, "cpu_ready in fill", 32'(cpu_ready), 32'd0);
            fill_ack = 1'b1; fill_way = fway;
            @(negedge clk);
            fill_ack = 1'b0;
            #1;
            check(rq, "fill_req drop", 32'(fill_req), 32'd0);
        end else begin
            check(rq, "no fill_req", 32'(fill_req), 32'd0);
            check(rq, "no wb_req", 32'(wb_req), 32'd0);
        end
    endtask

    // One-cycle snoop; an expected write-back is acknowledged at once.
    task automatic snp_op(input logic [31:0] a, input logic [4:0] tt, input logic g,
                          input logic er, input int rq);
        @(negedge clk);
        snp_valid = 1'b1; snp_gbl = g; snp_tt = tt; snp_addr = a;
        #1;
        check(rq, "snp_retry", 32'(snp_retry), 32'(er));
        @(negedge clk);
        snp_valid = 1'b0; snp_gbl = 1'b0;
        #1;
        check(rq, "wb_req", 32'(wb_req), 32'(er));
        if (er) begin
            check(rq, "wb_addr", wb_addr, {a[31:5], 5'b0});
            wb_ack = 1'b1;
            @(negedge clk);
            wb_ack = 1'b0;
            #1;
            check(rq, "wb_req drop", 32'(wb_req), 32'd0);
        end
    endtask

    // R1: release reset and count the cycles without cpu_ready.
    task automatic reset_and_sweep();
        int cnt;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(1, "reset fill_req", 32'(fill_req), 32'd0);
        check(1, "reset wb_req", 32'(wb_req), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cnt = 0;
        #1;
        while (!cpu_ready && cnt < 1000) begin
            cnt++;
            @(negedge clk);
            #1;
        end
        check(1, "sweep cycles", 32'(cnt), 32'd128);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        reset_and_sweep();  // R1

        for (int i = 0; i < 21; i++) begin
            if (VECS[i].op == 1'b0)
                cpu_op(VECS[i].addr, VECS[i].we, VECS[i].wim, VECS[i].exp_hit,
                       VECS[i].exp_st, VECS[i].way, int'(VECS[i].req));
            else
                snp_op(VECS[i].addr, VECS[i].tt, VECS[i].gbl, VECS[i].exp_retry,
                       int'(VECS[i].req));
        end

        // R11: snoop and lookup to the same set in one cycle; the snoop wins.
        cpu_op(A_ADR, 1'b1, 3'b001, 1'b1, SE, 1'b0, 11);
        @(negedge clk);
        snp_valid = 1'b1; snp_gbl = 1'b1; snp_tt = 5'b00010; snp_addr = A_ADR;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_wim = 3'b001; cpu_addr = A_ADR;
        #1;
        check(11, "same-set cpu_ready", 32'(cpu_ready), 32'd0);
        check(11, "same-set cpu_hit", 32'(cpu_hit), 32'd0);
        check(11, "same-set snp_retry", 32'(snp_retry), 32'd1);
        @(negedge clk);
        snp_valid = 1'b0; snp_gbl = 1'b0; cpu_req = 1'b0;
        #1;
        check(11, "same-set wb_req", 32'(wb_req), 32'd1);
        check(11, "same-set no fill", 32'(fill_req), 32'd0);
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        cpu_op(A_ADR, 1'b0, 3'b001, 1'b0, SI, 1'b0, 11);  // R11 snoop took effect
        // R11: a snoop to another set leaves the lookup served.
        @(negedge clk);
        snp_valid = 1'b1; snp_gbl = 1'b1; snp_tt = 5'b00010; snp_addr = C_ADR;
        cpu_req = 1'b1; cpu_addr = A_ADR;
        #1;
        check(11, "other-set cpu_ready", 32'(cpu_ready), 32'd1);
        check(11, "other-set cpu_hit", 32'(cpu_hit), 32'd1);
        check(11, "other-set snp_retry", 32'(snp_retry), 32'd0);
        @(negedge clk);
        snp_valid = 1'b0; snp_gbl = 1'b0; cpu_req = 1'b0;

        // R12: snoops during an outstanding write-back are retried and ignored.
        cpu_op(C_ADR, 1'b0, 3'b001, 1'b0, SI, 1'b0, 12);
        cpu_op(A_ADR, 1'b1, 3'b001, 1'b1, SE, 1'b0, 12);
        @(negedge clk);
        snp_valid = 1'b1; snp_gbl = 1'b1; snp_tt = 5'b00010; snp_addr = A_ADR;
        #1;
        check(12, "first snp_retry", 32'(snp_retry), 32'd1);
        @(negedge clk);
        snp_addr = C_ADR;
        #1;
        check(12, "wb pending", 32'(wb_req), 32'd1);
        check(12, "retry during wb", 32'(snp_retry), 32'd1);
        @(negedge clk);
        snp_valid = 1'b0; snp_gbl = 1'b0; wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        cpu_op(C_ADR, 1'b0, 3'b001, 1'b1, SE, 1'b0, 12);  // R12 C untouched

        // R12: a snoop to the set of an outstanding fill is retried and ignored.
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_wim = 3'b001; cpu_addr = D_ADR;
        #1;
        check(12, "D miss", 32'(cpu_hit), 32'd0);
        @(negedge clk);
        cpu_req = 1'b0;
        snp_valid = 1'b1; snp_gbl = 1'b1; snp_tt = 5'b00010; snp_addr = C_ADR;
        #1;
        check(12, "fill pending", 32'(fill_req), 32'd1);
        check(12, "retry on fill set", 32'(snp_retry), 32'd1);
        @(negedge clk);
        snp_valid = 1'b0; snp_gbl = 1'b0; fill_ack = 1'b1; fill_way = 1'b1;
        @(negedge clk);
        fill_ack = 1'b0;
        cpu_op(C_ADR, 1'b0, 3'b001, 1'b1, SE, 1'b0, 12);  // R12 C still E
        cpu_op(D_ADR, 1'b0, 3'b001, 1'b1, SE, 1'b1, 4);   // R4 D in way1

        // R1: a second reset clears the directory.
        reset_and_sweep();
        cpu_op(A_ADR, 1'b0, 3'b001, 1'b0, SI, 1'b0, 1);   // R1 lookup misses

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule